// File: doc/BRIEF.md
# PHY Management Register Bridge

The bridge gives a 16-bit host bus access to a bank of 32-bit MAC control registers. Each register is reached through two halfword slots. A write to slot 0 only loads a staging latch. A write to slot 1 commits the staged halfword together with the new one as a single 32-bit value, and runs that register's side effect in the same cycle.

Two registers have side effects. The mode register, at index 0, clears its soft-reset request when it is committed and reports both MAC directions idle. The station-management register, at index 1, carries out reads and writes of PHY registers. It works against an internal file of 32 sixteen-bit registers rather than a serial management line. On reads it overlays link-status bits while the link is up. It flags completion in its own done bit. All other registers store and return the committed value unchanged.

Top module: `mgmt_reg_bridge`

## Requirements
- R1: After reset every MAC register, every staging latch and every PHY register is zero, and reads return 0.
- R2: A write to slot 0 (addr_i bit 0 = 0) only stages data. Reads of either slot return the previous committed value until a slot-1 write arrives.
- R3: A write to slot 1 commits the value {staged halfword, wdata_i}. A read of slot 0 returns bits [31:16] and a read of slot 1 returns bits [15:0]. Read data appears on rdata_o one clock after the read request. Registers at index 2 and above return the committed value unchanged.
- R4: A station commit (index 1) with bit 13 set loads bits [31:16] with the PHY register addressed by bits [4:0] and sets done bit 15.
- R5: A station commit with bit 14 set stores bits [31:16] into the addressed PHY register and sets done bit 15.
- R6: When bits 13 and 14 are both set, the read happens first. The value written back to the PHY register is the value that was read, including any overlay.
- R7: While link_up_i is 1, station reads of PHY register 1 return bits 2 and 5 forced to 1. While link_up_i is 0, the stored value is returned as is.
- R8: While link_up_i is 1, station reads of PHY register 16 return bits 0, 1, 2 and 4 forced to 1.
- R9: A station write to PHY register 0 stores the data with bit 15 cleared and bit 0 set.
- R10: A mode commit (index 0) stores the value with bit 13 cleared and bits 14 and 15 set, and also sets done bit 15 of the station register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| link_up_i | input | 1 | Link state used for status overlay |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | {register index, slot} |
| wdata_i | input | 16 | Write halfword |
| rdata_o | output | 16 | Read halfword, registered |

## Verification
Plain registers are exercised with random staged/committing halfword pairs. These separate a correct commit from one that fires on slot 0, or one that swaps the two halves. Station commits are driven with every flag combination (none, read, write, both) at random PHY addresses. This separates read-before-write ordering from the reverse, and shows that done stays clear without a flag. The overlay registers 0, 1 and 16 are hit with link_up_i toggled and random stored contents. This exposes masks that are misplaced, missing, or applied while the link is down. Mode commits use random values with bits 13 to 15 in all states.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int PHY_AW = 5;
  localparam int PHY_NUM = 1 << PHY_AW;

  localparam int STA_RD_BIT   = 13;
  localparam int STA_WR_BIT   = 14;
  localparam int STA_DONE_BIT = 15;

  localparam int MODE_SRST_BIT   = 13;
  localparam int MODE_RXIDLE_BIT = 14;
  localparam int MODE_TXIDLE_BIT = 15;

  localparam int PHY_CTRL_IDX = 0;
  localparam int PHY_STAT_IDX = 1;
  localparam int PHY_EXT_IDX  = 16;

  localparam logic [15:0] STAT_FORCE = 16'h0024;
  localparam logic [15:0] EXT_FORCE  = 16'h0017;
  localparam logic [15:0] CTRL_CLR   = 16'h8000;
  localparam logic [15:0] CTRL_SET   = 16'h0001;
endpackage

// File: rtl/mgmt_phy_file.sv
module mgmt_phy_file
  import mgmt_pkg::*;
#(
  parameter int AW = PHY_AW,
  localparam int N = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          link_up_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [15:0]   rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [15:0]   wr_data_i
);
  logic [15:0] mem_q [N];
  logic [15:0] wr_fix;

  always_comb begin
    wr_fix = wr_data_i;
    if (wr_addr_i == AW'(PHY_CTRL_IDX)) wr_fix = (wr_data_i & ~CTRL_CLR) | CTRL_SET;
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(g)) mem_q[g] <= wr_fix;
    end
  end

  always_comb begin
    rd_data_o = mem_q[rd_addr_i];
    if (link_up_i) begin
      if (rd_addr_i == AW'(PHY_STAT_IDX)) rd_data_o = rd_data_o | STAT_FORCE;
      if (rd_addr_i == AW'(PHY_EXT_IDX))  rd_data_o = rd_data_o | EXT_FORCE;
    end
  end

  // R9
  ctrl_sanitize_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == AW'(PHY_CTRL_IDX) |=> !mem_q[PHY_CTRL_IDX][15] && mem_q[PHY_CTRL_IDX][0]);
  // R7
  stat_overlay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_i && rd_addr_i == AW'(PHY_STAT_IDX) |-> (rd_data_o & STAT_FORCE) == STAT_FORCE);
  // R8
  ext_overlay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_i && rd_addr_i == AW'(PHY_EXT_IDX) |-> (rd_data_o & EXT_FORCE) == EXT_FORCE);
endmodule

// File: rtl/mgmt_commit.sv
module mgmt_commit
  import mgmt_pkg::*;
#(
  parameter int AW = PHY_AW
) (
  input  logic          is_sta_i,
  input  logic          is_mode_i,
  input  logic [31:0]   raw_i,
  output logic [AW-1:0] phy_addr_o,
  input  logic [15:0]   phy_rd_data_i,
  output logic          phy_wr_o,
  output logic [15:0]   phy_wr_data_o,
  output logic [31:0]   val_o,
  output logic          set_done_o
);
  assign phy_addr_o = raw_i[AW-1:0];

  always_comb begin
    val_o         = raw_i;
    phy_wr_o      = 1'b0;
    set_done_o    = 1'b0;
    if (is_sta_i) begin
      // read precedes write: a combined op writes back what it read
      if (raw_i[STA_RD_BIT]) begin
        val_o[31:16]        = phy_rd_data_i;
        val_o[STA_DONE_BIT] = 1'b1;
      end
      if (raw_i[STA_WR_BIT]) begin
        phy_wr_o            = 1'b1;
        val_o[STA_DONE_BIT] = 1'b1;
      end
    end else if (is_mode_i) begin
      val_o[MODE_SRST_BIT]   = 1'b0;
      val_o[MODE_RXIDLE_BIT] = 1'b1;
      val_o[MODE_TXIDLE_BIT] = 1'b1;
      set_done_o             = 1'b1;
    end
    phy_wr_data_o = val_o[31:16];
  end
endmodule

// File: rtl/mgmt_reg_bridge.sv
module mgmt_reg_bridge
  import mgmt_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int MODE_IDX = 0,
  parameter int STA_IDX  = 1,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int AW    = IDX_W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          link_up_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o
);
  logic [31:0] regs_q  [NUM_REGS];
  logic [15:0] stage_q [NUM_REGS];

  logic [IDX_W-1:0] idx;
  logic             slot, idx_ok, stage_en, commit_en;
  logic [31:0]      commit_raw, commit_val;
  logic [PHY_AW-1:0] phy_addr;
  logic [15:0]      phy_rd_data, phy_wr_data;
  logic             phy_wr, set_done;

  assign idx        = addr_i[AW-1:1];
  assign slot       = addr_i[0];
  assign idx_ok     = 32'(idx) < NUM_REGS;
  assign stage_en   = req_i && we_i && !slot && idx_ok;
  assign commit_en  = req_i && we_i && slot && idx_ok;
  assign commit_raw = {stage_q[idx], wdata_i};

  mgmt_commit #(.AW(PHY_AW)) u_commit (
    .is_sta_i      (idx == IDX_W'(STA_IDX)),
    .is_mode_i     (idx == IDX_W'(MODE_IDX)),
    .raw_i         (commit_raw),
    .phy_addr_o    (phy_addr),
    .phy_rd_data_i (phy_rd_data),
    .phy_wr_o      (phy_wr),
    .phy_wr_data_o (phy_wr_data),
    .val_o         (commit_val),
    .set_done_o    (set_done)
  );

  mgmt_phy_file #(.AW(PHY_AW)) u_phy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .link_up_i (link_up_i),
    .rd_addr_i (phy_addr),
    .rd_data_o (phy_rd_data),
    .wr_en_i   (commit_en && phy_wr),
    .wr_addr_i (phy_addr),
    .wr_data_i (phy_wr_data)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g]  <= '0;
        stage_q[g] <= '0;
      end else begin
        if (stage_en && idx == IDX_W'(g)) stage_q[g] <= wdata_i;
        if (commit_en && idx == IDX_W'(g)) regs_q[g] <= commit_val;
        else if (g == STA_IDX && commit_en && set_done) regs_q[g][STA_DONE_BIT] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (req_i && !we_i) rdata_o <= !idx_ok ? 16'h0 : (slot ? regs_q[idx][15:0] : regs_q[idx][31:16]);
  end

  // R2
  stage_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_en |=> regs_q[$past(idx)] == $past(regs_q[idx]));
  // R4
  sta_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_en && idx == IDX_W'(STA_IDX) && (wdata_i[STA_RD_BIT] || wdata_i[STA_WR_BIT])
    |=> regs_q[STA_IDX][STA_DONE_BIT]);
  // R10
  mode_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_en && idx == IDX_W'(MODE_IDX)
    |=> regs_q[MODE_IDX][15:13] == 3'b110 && regs_q[STA_IDX][STA_DONE_BIT]);
endmodule

// File: tb/sim_mgmt_reg_bridge.sv
module sim_mgmt_reg_bridge;
  logic clk = 0, rst_n = 0, link = 0, req = 0, we = 0;
  logic [3:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  int checks = 0, errors = 0;

  logic [31:0] m_reg [8];
  logic [15:0] m_stg [8];
  logic [15:0] m_phy [32];

  always #2 clk = ~clk;

  mgmt_reg_bridge u0 (.clk_i(clk), .rst_ni(rst_n), .link_up_i(link), .req_i(req),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  function automatic logic [15:0] phy_view(int a);
    logic [15:0] v = m_phy[a];
    if (link && a == 1)  v |= 16'h0024;
    if (link && a == 16) v |= 16'h0017;
    return v;
  endfunction

  function automatic void model_write(int idx, int slot, logic [15:0] d);
    logic [31:0] v;
    logic [15:0] w;
    int a;
    if (slot == 0) begin m_stg[idx] = d; return; end
    v = {m_stg[idx], d};
    if (idx == 1) begin
      a = int'(v[4:0]);
      if (v[13]) begin v[31:16] = phy_view(a); v[15] = 1'b1; end
      if (v[14]) begin
        w = v[31:16];
        if (a == 0) begin w[15] = 1'b0; w[0] = 1'b1; end
        m_phy[a] = w; v[15] = 1'b1;
      end
      m_reg[1] = v;
    end else if (idx == 0) begin
      v[13] = 1'b0; v[15:14] = 2'b11;
      m_reg[0] = v; m_reg[1][15] = 1'b1;
    end else m_reg[idx] = v;
  endfunction

  task automatic wr(int idx, int slot, logic [15:0] d);
    req = 1; we = 1; addr = {3'(idx), 1'(slot)}; wdata = d;
    model_write(idx, slot, d);
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd_chk(int idx, int slot, string tag);
    logic [15:0] exp;
    req = 1; we = 0; addr = {3'(idx), 1'(slot)};
    @(negedge clk); req = 0;
    exp = slot ? m_reg[idx][15:0] : m_reg[idx][31:16];
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s reg %0d slot %0d actual %h expected %h", tag, idx, slot, rdata, exp);
    end
  endtask

  task automatic wr32(int idx, logic [31:0] v);
    wr(idx, 0, v[31:16]); wr(idx, 1, v[15:0]);
  endtask

  task automatic phy_read_chk(int a, string tag);
    wr32(1, 32'h0000_2000 | 32'(a)); rd_chk(1, 0, tag); rd_chk(1, 1, tag);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd77));
    for (int i = 0; i < 8; i++) begin m_reg[i] = '0; m_stg[i] = '0; end
    for (int i = 0; i < 32; i++) m_phy[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);

    for (int i = 0; i < 8; i++) rd_chk(i, i % 2, "R1 reset");
    phy_read_chk(5, "R1 phy reset");
    phy_read_chk(16, "R1 phy reset");

    wr(3, 0, 16'hBEEF); rd_chk(3, 0, "R2 staged only"); rd_chk(3, 1, "R2 staged only");
    wr(3, 1, 16'h1234); rd_chk(3, 0, "R3 commit hi"); rd_chk(3, 1, "R3 commit lo");

    wr32(1, 32'hA5A5_4007); phy_read_chk(7, "R5 phy write");
    wr32(1, 32'h0000_0007); rd_chk(1, 1, "R4 no flag no done");
    wr32(1, 32'hFFFF_4000); phy_read_chk(0, "R9 ctrl sanitize");
    wr32(1, 32'h0000_4001); link = 0; phy_read_chk(1, "R7 link down raw");
    link = 1; phy_read_chk(1, "R7 link up overlay");
    phy_read_chk(16, "R8 ext overlay");
    wr32(1, 32'h1234_6010); phy_read_chk(16, "R6 read then write");
    link = 0; phy_read_chk(16, "R6 written back overlay");
    wr32(1, 32'h0000_0002); wr32(0, 32'h0F0F_2F0F);
    rd_chk(0, 1, "R10 mode bits"); rd_chk(1, 1, "R10 sta done");

    for (int n = 0; n < 600; n++) begin
      int k = int'($urandom_range(0, 9));
      if (k == 0) link = 1'($urandom);
      if (k < 4) begin
        int r = int'($urandom_range(2, 7));
        wr(r, int'($urandom_range(0, 1)), 16'($urandom));
        rd_chk(r, int'($urandom_range(0, 1)), "R3 random plain");
      end else if (k < 8) begin
        logic [31:0] v = $urandom;
        int pick = int'($urandom_range(0, 3));
        if (pick == 0) v[4:0] = 5'd0; else if (pick == 1) v[4:0] = 5'd1;
        else if (pick == 2) v[4:0] = 5'd16;
        wr32(1, v); rd_chk(1, 0, "R4 R5 random station"); rd_chk(1, 1, "R6 random station");
      end else begin
        wr32(0, $urandom); rd_chk(0, 1, "R10 random mode"); rd_chk(1, 1, "R10 random done");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule